// File: doc/BRIEF.md
# Secondary Codec Command Receiver

This block sits on the codec side of a serial audio link. It watches the frame-sync line and takes the serial output stream from the controller one bit at a time. It rebuilds the 16-bit tag slot and the two 20-bit command slots that follow it, and decides whether the frame carries a register access meant for this codec. The codec is strapped with a two-bit identity, which must be nonzero. The block claims a frame only when that frame is marked valid and its tag slot names this identity. The two command tag flags in the tag slot play no part in that decision.

For every access it claims, the block presents a read/write flag, a 7-bit register index and, for writes, 16 bits of write data. It also raises a command strobe for exactly one system-clock cycle. The register file consumes these outputs. The bit clock, sync and serial data are inputs sampled in the system clock domain and must be synchronous to it. The system clock must run at least twice as fast as the bit clock. A bit is taken only on a falling edge of the bit clock.

Top module: `sec_cmd_rx`

## Requirements
- R1: While reset is held and after it is released, cmd_valid is 0 and cmd_read, cmd_index and cmd_wdata are all zero until the first accepted command.
- R2: Sync and data are sampled only on falling edges of bclk. A frame starts on the falling edge at which sync is sampled high after having been sampled low at the previous falling edge. A sync pulse that is high only while bclk is high starts nothing.
- R3: After the start edge, the following 56 falling edges carry the tag slot (16 bits), slot 1 (20 bits) and slot 2 (20 bits), each sent MSB first. Slot 1 bit 19 is the read flag (1 = read) and slot 1 bits 18:12 are the register index. Slot 2 bits 19:4 are the write data, and slot 2 bits 3:0 are discarded.
- R4: When tag bit 15 (frame valid) is 0, the frame produces no strobe and the outputs are left unchanged, whatever the ID bits hold.
- R5: Tag bits 14 and 13 have no effect on acceptance.
- R6: A frame is accepted only if tag bits 1:0 equal dev_id and dev_id is nonzero. A frame whose ID bits differ, including ID 00, is ignored.
- R7: For an accepted frame, cmd_valid is high for exactly one clk cycle. That cycle follows the clk edge that samples the falling bclk edge carrying slot 2 bit 0. No strobe occurs earlier in the frame.
- R8: When cmd_valid is low, cmd_read, cmd_index and cmd_wdata hold their last values.
- R9: If sync is seen rising again before slot 2 is complete, the partial frame is discarded and reception restarts at tag bit 15.
- R10: Once slot 2 has been received, further bits are ignored until the next sync rise.
- R11: An accepted read updates cmd_read and cmd_index but leaves cmd_wdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Link bit clock, synchronous to clk |
| frame_sync | input | 1 | Frame sync line |
| ser_in | input | 1 | Serial output stream from the controller |
| dev_id | input | 2 | This codec's nonzero identity |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_read | output | 1 | 1 = read access, 0 = write |
| cmd_index | output | 7 | Register index |
| cmd_wdata | output | 16 | Write data |

## Verification
The strobe and all command fields are due one clk cycle after the clk edge at which bclk is first seen low for slot 2 bit 0. The strobe is gone one cycle later. The bench drives every input on falling clk edges. It samples the outputs on the falling clk edge right after that processing edge, and again one edge later, so both the strobe's start and its one-cycle width are checked at the cycle where they are due. During each frame the bench also samples the strobe after every bit, which catches a strobe raised early. Between frames it checks that the fields hold.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int TAG_W    = 16;
  localparam int SLOT_W   = 20;
  localparam int ID_W     = 2;
  localparam int IDX_W    = 7;
  localparam int DATA_W   = 16;
  localparam int FV_BIT   = 15;
  localparam int RD_BIT   = 19;
  localparam int IDX_LSB  = 12;
  localparam int DATA_LSB = 4;

  // Acceptance rule: frame valid set and the ID field naming this nonzero codec
  function automatic logic tag_selects(input logic frame_ok,
                                       input logic [ID_W-1:0] id_field,
                                       input logic [ID_W-1:0] my_id);
    return frame_ok && (my_id != '0) && (id_field == my_id);
  endfunction
endpackage

// File: rtl/cmdrx_framer.sv
module cmdrx_framer #(
  parameter int FRAME_BITS = 56,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             frame_sync,
  output logic             frame_start,
  output logic             bit_stb,
  output logic [CNT_W-1:0] bit_pos
);
  logic             bclk_q;
  logic             sync_q;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             fall_evt;

  assign fall_evt    = bclk_q & ~bclk;
  assign frame_start = fall_evt & frame_sync & ~sync_q;
  assign bit_stb     = fall_evt & active & ~frame_start;
  assign bit_pos     = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      sync_q <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      bclk_q <= bclk;
      if (fall_evt) sync_q <= frame_sync;
      if (frame_start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (bit_stb) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(FRAME_BITS - 1)) active <= 1'b0;
      end
    end
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_pos == '0));
endmodule

// File: rtl/cmdrx_deser.sv
module cmdrx_deser
  import cmdrx_pkg::*;
#(
  parameter int FRAME_BITS = TAG_W + 2 * SLOT_W,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic [CNT_W-1:0]  bit_pos,
  input  logic              ser_in,
  output logic              frame_ok,
  output logic [ID_W-1:0]   id_field,
  output logic              rd_flag,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] wr_word,
  output logic              last_evt
);
  localparam int TAG_END = TAG_W - 1;
  localparam int S1_END  = TAG_W + SLOT_W - 1;
  localparam int S2_END  = FRAME_BITS - 1;

  logic [SLOT_W-2:0] sh;
  logic [SLOT_W-1:0] next_sh;
  logic              tag_end_evt;
  logic              s1_end_evt;

  assign next_sh     = {sh, ser_in};
  assign tag_end_evt = bit_stb && (bit_pos == CNT_W'(TAG_END));
  assign s1_end_evt  = bit_stb && (bit_pos == CNT_W'(S1_END));
  assign last_evt    = bit_stb && (bit_pos == CNT_W'(S2_END));
  assign wr_word     = next_sh[DATA_LSB +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      frame_ok <= 1'b0;
      id_field <= '0;
      rd_flag  <= 1'b0;
      reg_idx  <= '0;
    end else begin
      if (bit_stb) sh <= next_sh[SLOT_W-2:0];
      if (tag_end_evt) begin
        frame_ok <= next_sh[FV_BIT];
        id_field <= next_sh[ID_W-1:0];
      end
      if (s1_end_evt) begin
        rd_flag <= next_sh[RD_BIT];
        reg_idx <= next_sh[IDX_LSB +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/cmdrx_match.sv
module cmdrx_match
  import cmdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_evt,
  input  logic              frame_ok,
  input  logic [ID_W-1:0]   id_field,
  input  logic              rd_flag,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [ID_W-1:0]   dev_id,
  output logic              cmd_valid,
  output logic              cmd_read,
  output logic [IDX_W-1:0]  cmd_index,
  output logic [DATA_W-1:0] cmd_wdata
);
  logic accept_evt;

  assign accept_evt = last_evt && tag_selects(frame_ok, id_field, dev_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_read  <= 1'b0;
      cmd_index <= '0;
      cmd_wdata <= '0;
    end else begin
      cmd_valid <= accept_evt;
      if (accept_evt) begin
        cmd_read  <= rd_flag;
        cmd_index <= reg_idx;
        if (!rd_flag) cmd_wdata <= wr_word;
      end
    end
  end

  // R7
  strb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R7
  strb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(last_evt));

  // R4
  frame_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> frame_ok);

  // R6
  id_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (id_field == $past(dev_id)) && ($past(dev_id) != '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable({cmd_read, cmd_index, cmd_wdata}));

  // R11
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_read) |-> $stable(cmd_wdata));
endmodule

// File: rtl/sec_cmd_rx.sv
module sec_cmd_rx
  import cmdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              frame_sync,
  input  logic              ser_in,
  input  logic [ID_W-1:0]   dev_id,
  output logic              cmd_valid,
  output logic              cmd_read,
  output logic [IDX_W-1:0]  cmd_index,
  output logic [DATA_W-1:0] cmd_wdata
);
  localparam int FRAME_BITS = TAG_W + 2 * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic              frame_start;
  logic              bit_stb;
  logic [CNT_W-1:0]  bit_pos;
  logic              frame_ok;
  logic [ID_W-1:0]   id_field;
  logic              rd_flag;
  logic [IDX_W-1:0]  reg_idx;
  logic [DATA_W-1:0] wr_word;
  logic              last_evt;

  cmdrx_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .frame_sync(frame_sync),
    .frame_start(frame_start), .bit_stb(bit_stb), .bit_pos(bit_pos)
  );

  cmdrx_deser #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_pos(bit_pos),
    .ser_in(ser_in), .frame_ok(frame_ok), .id_field(id_field),
    .rd_flag(rd_flag), .reg_idx(reg_idx), .wr_word(wr_word),
    .last_evt(last_evt)
  );

  cmdrx_match u_match (
    .clk(clk), .rst_n(rst_n), .last_evt(last_evt), .frame_ok(frame_ok),
    .id_field(id_field), .rd_flag(rd_flag), .reg_idx(reg_idx),
    .wr_word(wr_word), .dev_id(dev_id), .cmd_valid(cmd_valid),
    .cmd_read(cmd_read), .cmd_index(cmd_index), .cmd_wdata(cmd_wdata)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !cmd_valid);
endmodule

// File: tb/sec_cmd_rx_bench.sv
module sec_cmd_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        frame_sync = 1'b0;
  logic        ser_in = 1'b0;
  logic [1:0]  dev_id = 2'd1;
  logic        cmd_valid;
  logic        cmd_read;
  logic [6:0]  cmd_index;
  logic [15:0] cmd_wdata;

  int checks = 0;
  int fails  = 0;

  logic        mdl_rd = 1'b0;
  logic [6:0]  mdl_idx = '0;
  logic [15:0] mdl_wd = '0;

  always #4 clk = ~clk;

  sec_cmd_rx u_sec_cmd_rx (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .frame_sync(frame_sync),
    .ser_in(ser_in), .dev_id(dev_id), .cmd_valid(cmd_valid),
    .cmd_read(cmd_read), .cmd_index(cmd_index), .cmd_wdata(cmd_wdata)
  );

  // {dev_id, tag slot, slot 1, slot 2, strobe expected}
  localparam logic [58:0] VEC [0:7] = '{
    {2'd1, 16'h8001, 20'h2A000, 20'hBEEF0, 1'b1},  // write, matching
    {2'd1, 16'h0001, 20'h15000, 20'h12340, 1'b0},  // frame valid clear (R4)
    {2'd2, 16'h8002, 20'hFF000, 20'hAAAA0, 1'b1},  // read: wdata kept (R11)
    {2'd2, 16'hE002, 20'h05000, 20'h5A5A0, 1'b1},  // tag flags set (R5)
    {2'd3, 16'hE001, 20'h44000, 20'h44440, 1'b0},  // ID mismatch (R6)
    {2'd3, 16'h8000, 20'h46000, 20'h46460, 1'b0},  // ID 00 (R6)
    {2'd3, 16'h9FFF, 20'h7F000, 20'h0001F, 1'b1},  // noisy tag, low nibble dropped (R3)
    {2'd1, 16'h8003, 20'h48000, 20'h48480, 1'b0}   // ID mismatch (R6)
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Wrong data on the bclk rise, correct data before the fall (R2)
  task automatic put_bit(input logic d, input logic s);
    @(negedge clk) begin bclk = 1'b1; ser_in = ~d; frame_sync = s; end
    @(negedge clk) ser_in = d;
    @(negedge clk) bclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] tg, input logic [19:0] s1,
                            input logic [19:0] s2, input int nbits,
                            output int early, output logic v1, output logic v2);
    logic [55:0] fr;
    fr = {tg, s1, s2};
    early = 0;
    put_bit(1'b0, 1'b1);
    if (cmd_valid) early++;
    for (int i = 0; i < nbits; i++) begin
      put_bit(fr[55-i], i < 15);
      if (i != 55 && cmd_valid) early++;
    end
    v1 = cmd_valid;
    @(negedge clk) v2 = cmd_valid;
  endtask

  task automatic idle_bits(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      put_bit(1'b0, 1'b0);
      if (cmd_valid) seen++;
    end
  endtask

  task automatic chk_fields(input string req);
    chk(req, 32'(cmd_read), 32'(mdl_rd));
    chk(req, 32'(cmd_index), 32'(mdl_idx));
    chk(req, 32'(cmd_wdata), 32'(mdl_wd));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog actual=still running expected=finished");
    finish_run();
  end

  initial begin
    int early;
    int seen;
    logic v1;
    logic v2;
    logic [55:0] raw;

    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk("R1", 32'(cmd_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", 32'(cmd_valid), 0);
    chk_fields("R1");

    // Table walk: acceptance (R4 R5 R6), strobe timing (R7), field mapping (R3 R8 R11)
    for (int k = 0; k < 8; k++) begin
      dev_id = VEC[k][58:57];
      send_frame(VEC[k][56:41], VEC[k][40:21], VEC[k][20:1], 56, early, v1, v2);
      chk("R7 early", 32'(early), 0);
      chk("R4 R5 R6 strobe", 32'(v1), 32'(VEC[k][0]));
      chk("R7 width", 32'(v2), 0);
      if (VEC[k][0]) begin
        mdl_rd  = VEC[k][40];
        mdl_idx = VEC[k][39:33];
        if (!VEC[k][40]) mdl_wd = VEC[k][20:5];
        chk_fields(VEC[k][40] ? "R3 R11" : "R3");
      end else begin
        chk_fields("R8");
      end
      idle_bits(3, seen);
      chk("R10 idle", 32'(seen), 0);
    end

    // R9: partial frame discarded, restart on new sync rise
    dev_id = 2'd1;
    send_frame(16'h8001, 20'h11000, 20'h11110, 30, early, v1, v2);
    chk("R9 partial", 32'(early + int'(v1) + int'(v2)), 0);
    send_frame(16'h8001, 20'h22000, 20'h22220, 56, early, v1, v2);
    chk("R9 restart strobe", 32'({early[0], v1, v2}), 32'b010);
    mdl_rd = 1'b0; mdl_idx = 7'h22; mdl_wd = 16'h2222;
    chk_fields("R9");

    // R10: bits after slot 2 without a sync rise are ignored
    raw = {16'h8001, 20'h33000, 20'h33330};
    seen = 0;
    for (int i = 0; i < 56; i++) begin
      put_bit(raw[55-i], 1'b0);
      if (cmd_valid) seen++;
    end
    chk("R10 trailing", 32'(seen), 0);
    chk_fields("R10");

    // R2: sync high only while bclk is high starts no frame
    @(negedge clk) begin bclk = 1'b1; frame_sync = 1'b1; end
    @(negedge clk) frame_sync = 1'b0;
    @(negedge clk) bclk = 1'b0;
    @(negedge clk);
    seen = 0;
    for (int i = 0; i < 56; i++) begin
      put_bit(raw[55-i], 1'b0);
      if (cmd_valid) seen++;
    end
    chk("R2 rise-only sync", 32'(seen), 0);
    chk_fields("R2");

    // R1: reset mid-run clears fields
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mdl_rd = 1'b0; mdl_idx = '0; mdl_wd = '0;
    chk_fields("R1 reset");

    finish_run();
  end
endmodule